// File: doc/BRIEF.md
# Dual-Role Byte-Wide SPI Shift Port

This block moves one byte at a time over a four-wire serial link and can take either end of the link. A mode input chooses the role. As bus master the port makes its own serial clock from the system clock and drives an active-low select line. As a slave it follows a clock and a select line that come from outside. In both roles a single eight-bit data register holds the byte to send and then the byte that was received. Each bit leaves from the top of that register as a new bit enters at the bottom, most significant bit first.

Software talks to the port through a write strobe with a byte, a read-back of the data register, a busy indication, and a sticky completion flag with a clear strobe. Two configuration inputs set the clock's resting level and whether bits are sampled on the edge that leaves the resting level or on the edge that returns to it. A halt input stands for the processor core being stopped, and the port ignores it.

The control machine has four states. ST_OFF is entered whenever the enable is low. ST_IDLE is entered from ST_OFF when the enable rises. ST_IDLE goes to ST_MRUN on a data write in master mode, and to ST_SRUN when the synchronised select input is low in slave mode. ST_MRUN returns to ST_IDLE after its sixteenth clock edge. ST_SRUN returns to ST_IDLE when the select input rises or the mode changes to master. Any running state falls to ST_OFF when the enable drops.

Top module: `spi_duo_port`

## Requirements
- R1: While `en` is low the port does nothing. A write strobe does not load the data register, `sck_out` stays at its resting level, and `busy` stays low.
- R2: In master mode, with the port idle, a write strobe loads `wr_byte` and starts a full-duplex exchange. The eight bits of `wr_byte` leave on `sdo` most significant first. The eight bits seen on `sdi` at the sampling edges end up in the data register, first bit in bit 7.
- R3: A master exchange produces exactly 16 clock edges. Each half period is `div_half` system cycles, and a value of 0 acts as 1. `busy` rises one cycle after the write. `busy` falls and `done` rises 16*`div_half` cycles after the write edge. `scs_n_out` is low only while the master exchange runs.
- R4: `done` stays high once set until a `clr_done` strobe clears it. If a completion and a clear happen in the same cycle, the completion wins.
- R5: A write strobe during a master exchange is ignored. It changes neither the bits being sent nor the byte received.
- R6: In slave mode, with `scs_n_in` low, the data register shifts out on `sdo` and takes in `sdi` on the external clock. `done` is set once the eighth bit has been sampled.
- R7: In slave mode, clock edges that arrive while `scs_n_in` is high are ignored. The data register keeps its value, `done` is not set, and `busy` stays low.
- R8: If `scs_n_in` rises before a slave byte completes, the bit count restarts and `done` is not set. The next byte after that is received in full.
- R9: `cpol` gives the resting level of the clock (1 = rests high). `sample_trail` = 0 samples on the edge leaving the resting level, and `sample_trail` = 1 samples on the edge returning to it. Rising or falling follows from the two bits together.
- R10: The `halt` input does not slow, stop or alter any exchange.
- R11: After reset, `busy` and `done` are 0, the data register is 0x00, `scs_n_out` is 1 and `sck_out` rests at `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable |
| mode_master | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Clock resting level |
| sample_trail | input | 1 | 1 = sample on the edge returning to rest |
| div_half | input | DIVW | Master half period in system cycles |
| halt | input | 1 | Core halted indication (no effect) |
| wr_data | input | 1 | Data register write strobe |
| wr_byte | input | DW | Byte to write |
| clr_done | input | 1 | Completion flag clear strobe |
| rd_byte | output | DW | Data register contents |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Sticky completion flag |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master role |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| scs_n_in | input | 1 | Active-low select from an external master |
| scs_n_out | output | 1 | Active-low select driven in master role |

## Verification
The bench runs all four clock modes in both roles, at divider values 0, 1, 2 and 3. It checks the exact cycle at which `done` and `busy` change, so an off-by-one half period or a missing final edge shows up as a timing mismatch. In trailing-sample mode the last bit shifts in on the final edge, and a core that drops it returns a byte missing its last bit. A write during a transfer that is wrongly accepted corrupts both the outgoing bits and the received byte. A slave that shifts with the select line high changes the register. A slave that keeps its bit count across an aborted select sets `done` early or returns a rotated byte.

// File: rtl/spi_duo_pkg.sv
package spi_duo_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_MRUN,
        ST_SRUN
    } port_state_e;

endpackage

// File: rtl/spi_half_timer.sv
// Counts system cycles within one serial half period and pulses at its end.
module spi_half_timer #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] half,
    output logic            tick
);
    localparam logic [DIVW:0] ONE_W = (DIVW+1)'(1);

    logic [DIVW-1:0] cnt;
    logic            at_end;

    // A half value of zero behaves as one.
    assign at_end = ({1'b0, cnt} + ONE_W) >= {1'b0, half};
    assign tick   = run & at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIVW'(1);
        end
    end
endmodule

// File: rtl/spi_pin_sync.sv
// Multi-stage synchroniser for asynchronous pins.
module spi_pin_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RSTV   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RSTV}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
// Shared data register: sample edges capture a bit, shift edges move it in.
// The last bit of a byte is shifted in directly on its sample edge.
module spi_shift_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          sample_ev,
    input  logic          shift_ev,
    input  logic          bit_in,
    output logic [DW-1:0] data,
    output logic          byte_done
);
    localparam int CW = $clog2(DW);

    logic [CW-1:0] cnt;
    logic          pend;
    logic          hold;
    logic          last_bit;

    assign last_bit  = (cnt == CW'(DW-1));
    assign byte_done = sample_ev & last_bit & ~load & ~clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
            pend <= 1'b0;
            hold <= 1'b0;
        end else if (load) begin
            data <= load_val;
            cnt  <= '0;
            pend <= 1'b0;
        end else if (clear) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (sample_ev) begin
            if (last_bit) begin
                data <= {data[DW-2:0], bit_in};
                cnt  <= '0;
                pend <= 1'b0;
            end else begin
                hold <= bit_in;
                pend <= 1'b1;
                cnt  <= cnt + CW'(1);
            end
        end else if (shift_ev && pend) begin
            data <= {data[DW-2:0], hold};
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_duo_port.sv
module spi_duo_port
    import spi_duo_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            mode_master,
    input  logic            cpol,
    input  logic            sample_trail,
    input  logic [DIVW-1:0] div_half,
    input  logic            halt,
    input  logic            wr_data,
    input  logic [DW-1:0]   wr_byte,
    input  logic            clr_done,
    output logic [DW-1:0]   rd_byte,
    output logic            busy,
    output logic            done,
    input  logic            sck_in,
    output logic            sck_out,
    input  logic            sdi,
    output logic            sdo,
    input  logic            scs_n_in,
    output logic            scs_n_out
);
    localparam int EDGES = 2 * DW;
    localparam int EW    = $clog2(EDGES);

    port_state_e state, nstate;

    logic          m_run, s_run;
    logic          tick;
    logic [EW-1:0] ecnt;
    logic          m_last;
    logic          sck_q, done_q;
    logic          sck_s, sdi_s, scsn_s, sck_p;
    logic          s_lead, s_trail;
    logic          lead_ev, trail_ev, samp_ev, shft_ev;
    logic          load, core_clear, core_done, bit_in;

    // Pin synchronisers for the slave role.
    spi_pin_sync #(
        .W      (3),
        .STAGES (2),
        .RSTV   (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, sdi, scs_n_in}),
        .q     ({sck_s, sdi_s, scsn_s})
    );

    spi_half_timer #(
        .DIVW (DIVW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_run),
        .half  (div_half),
        .tick  (tick)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nstate;
        end
    end

    // Next-state logic.
    always_comb begin
        nstate = state;
        unique case (state)
            ST_OFF: begin
                if (en) nstate = ST_IDLE;
            end
            ST_IDLE: begin
                if (!en)                          nstate = ST_OFF;
                else if (mode_master && wr_data)  nstate = ST_MRUN;
                else if (!mode_master && !scsn_s) nstate = ST_SRUN;
            end
            ST_MRUN: begin
                if (!en)         nstate = ST_OFF;
                else if (m_last) nstate = ST_IDLE;
            end
            ST_SRUN: begin
                if (!en)                       nstate = ST_OFF;
                else if (mode_master || scsn_s) nstate = ST_IDLE;
            end
            default: nstate = ST_OFF;
        endcase
    end

    // State-decoded outputs.
    always_comb begin
        m_run     = (state == ST_MRUN);
        s_run     = (state == ST_SRUN);
        busy      = m_run | s_run;
        scs_n_out = ~m_run;
        load      = en & (state == ST_IDLE) & wr_data;
        core_clear = ~(m_run | s_run);
    end

    // Edge events, from the own divider or the external clock.
    assign s_lead   = (sck_s != cpol) && (sck_p == cpol);
    assign s_trail  = (sck_s == cpol) && (sck_p != cpol);
    assign m_last   = m_run & tick & (ecnt == EW'(EDGES-1));
    assign lead_ev  = m_run ? (tick & ~ecnt[0]) : (s_run & ~scsn_s & s_lead);
    assign trail_ev = m_run ? (tick &  ecnt[0]) : (s_run & ~scsn_s & s_trail);
    assign samp_ev  = sample_trail ? trail_ev : lead_ev;
    assign shft_ev  = sample_trail ? lead_ev  : trail_ev;
    assign bit_in   = m_run ? sdi : sdi_s;

    spi_shift_core #(
        .DW (DW)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (core_clear),
        .load      (load),
        .load_val  (wr_byte),
        .sample_ev (samp_ev),
        .shift_ev  (shft_ev),
        .bit_in    (bit_in),
        .data      (rd_byte),
        .byte_done (core_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt   <= '0;
            sck_q  <= 1'b0;
            sck_p  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            sck_p <= sck_s;
            if (!m_run)    ecnt <= '0;
            else if (tick) ecnt <= ecnt + EW'(1);
            if (!m_run)    sck_q <= cpol;
            else if (tick) sck_q <= ~sck_q;
            if (m_last || (s_run && core_done)) done_q <= 1'b1;
            else if (clr_done)                  done_q <= 1'b0;
        end
    end

    assign sck_out = sck_q;
    assign sdo     = rd_byte[DW-1];
    assign done    = done_q;
endmodule

// File: rtl/spi_duo_port_chk.sv
module spi_duo_port_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cpol,
    input logic halt,
    input logic clr_done,
    input logic busy,
    input logic done,
    input logic sck_out,
    input logic scs_n_out
);
    p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    p_done_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    p_sel_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !scs_n_out |-> busy);

    p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_done) |=> done);

    p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clr_done && !busy) |=> !done);

    p_sck_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (sck_out == $past(cpol)));

    p_halt_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && en && !scs_n_out) |=> (!scs_n_out || done));
endmodule

bind spi_duo_port spi_duo_port_chk u_chk (.*);

// File: tb/spi_duo_port_tb.sv
module spi_duo_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1, mode_master = 1'b1, cpol = 1'b0, sample_trail = 1'b0;
    logic [7:0] div_half = 8'd2;
    logic       halt = 1'b0, wr_data = 1'b0, clr_done = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] rd_byte;
    logic       busy, done, sck_out, sdo, scs_n_out;
    logic       sck_in = 1'b0, sdi = 1'b0, scs_n_in = 1'b1;

    int checks = 0, fails = 0;
    bit trk = 1'b0;
    bit exp_busy = 1'b0, exp_done = 1'b0;
    logic [7:0] exp_data = 8'h00;

    always #5 clk = ~clk;

    spi_duo_port u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle reference comparison.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (trk) begin
                chk(busy == exp_busy, "R3 busy timing", busy, exp_busy);
                chk(done == exp_done, "R4 done flag", done, exp_done);
                if (!exp_busy) chk(rd_byte == exp_data, "R2 data register", rd_byte, exp_data);
            end
        end
    end

    task automatic clear_flag();
        @(negedge clk); clr_done = 1'b1;
        @(negedge clk); clr_done = 1'b0; exp_done = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R4 cleared", done, 0);
    endtask

    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] rxb, input int n_half,
                          input bit pol, input bit trl, input bit hit, input bit use_halt);
        logic [7:0] got;
        int edges, ns, eff;
        logic last_sdo, prev;
        got = '0; edges = 0; ns = 0;
        eff = (n_half == 0) ? 1 : n_half;
        mode_master = 1'b1; cpol = pol; sample_trail = trl; div_half = n_half[7:0];
        @(negedge clk);
        sdi = rxb[7];
        @(negedge clk); wr_byte = tx; wr_data = 1'b1; halt = use_halt;
        @(negedge clk); wr_data = 1'b0; exp_busy = 1'b1;
        last_sdo = sdo; prev = sck_out;
        for (int i = 0; i < 16*eff; i++) begin
            @(negedge clk);
            if (hit && i == eff) begin wr_byte = ~tx; wr_data = 1'b1; end
            else wr_data = 1'b0;
            if (i == 0) chk(scs_n_out == 1'b0, "R3 select low while running", scs_n_out, 0);
            if (sck_out != prev) begin
                bit lead, samp;
                edges++;
                lead = (edges % 2) == 1;
                samp = trl ? !lead : lead;
                if (samp) begin got = {got[6:0], last_sdo}; ns++; end
                else if (ns < 8) sdi = rxb[7-ns];
                prev = sck_out;
            end
            if (i == 16*eff-1) begin exp_busy = 1'b0; exp_done = 1'b1; exp_data = rxb; end
            last_sdo = sdo;
        end
        wr_data = 1'b0; halt = 1'b0;
        chk(got == tx, hit ? "R5 sent bits after ignored write" : "R2 bits sent MSB first", got, tx);
        chk(edges == 16, "R3 edge count", edges, 16);
        chk(sck_out == pol, "R9 resting level", sck_out, pol);
        chk(rd_byte == rxb, hit ? "R5 received byte after ignored write" : "R2 received byte", rd_byte, rxb);
        chk(scs_n_out == 1'b1, "R3 select released", scs_n_out, 1);
    endtask

    task automatic s_xfer(input logic [7:0] tx, input logic [7:0] rxb, input bit pol, input bit trl,
                          input bit hold_hi, input int n_edges, output logic [7:0] got);
        int ns;
        ns = 0; got = '0; trk = 1'b0;
        mode_master = 1'b0; cpol = pol; sample_trail = trl; sck_in = pol; scs_n_in = 1'b1;
        repeat (6) @(negedge clk);
        wr_byte = tx; wr_data = 1'b1;
        @(negedge clk); wr_data = 1'b0;
        sdi = rxb[7]; scs_n_in = hold_hi;
        repeat (6) @(negedge clk);
        chk(busy == !hold_hi, "R7 busy follows select", busy, !hold_hi);
        for (int e = 1; e <= n_edges; e++) begin
            bit lead, samp;
            lead = (e % 2) == 1;
            samp = trl ? !lead : lead;
            if (samp) begin got = {got[6:0], sdo}; ns++; end
            sck_in = ~sck_in;
            if (!samp && ns < 8) sdi = rxb[7-ns];
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        scs_n_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11 busy", busy, 0);
        chk(done == 1'b0, "R11 done", done, 0);
        chk(rd_byte == 8'h00, "R11 data", rd_byte, 0);
        chk(scs_n_out == 1'b1, "R11 select", scs_n_out, 1);
        chk(sck_out == 1'b0, "R11 clock rest", sck_out, 0);
        trk = 1'b1;

        m_xfer(8'hA5, 8'h3C, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk(done == 1'b1, "R4 sticky done", done, 1);
        clear_flag();

        m_xfer(8'h96, 8'h5B, 1, 1'b1, 1'b0, 1'b1, 1'b0);   // R5
        clear_flag();
        m_xfer(8'h0F, 8'hF0, 3, 1'b0, 1'b1, 1'b0, 1'b1);   // R10 with halt high, R9 mode
        clear_flag();
        m_xfer(8'hC6, 8'h39, 0, 1'b1, 1'b1, 1'b0, 1'b0);   // R3 zero divider, R9 mode
        clear_flag();

        // R1 enable low
        @(negedge clk); en = 1'b0;
        @(negedge clk); wr_byte = 8'h3C; wr_data = 1'b1;
        @(negedge clk); wr_data = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R1 no busy when disabled", busy, 0);
        chk(sck_out == cpol, "R1 clock quiet when disabled", sck_out, cpol);
        chk(rd_byte == exp_data, "R1 write ignored when disabled", rd_byte, exp_data);
        en = 1'b1;
        repeat (2) @(negedge clk);

        // R6 slave, modes 0 and 3
        s_xfer(8'h81, 8'h7E, 1'b0, 1'b0, 1'b0, 16, got);
        chk(got == 8'h81, "R6 slave sent bits", got, 8'h81);
        chk(rd_byte == 8'h7E, "R6 slave received", rd_byte, 8'h7E);
        chk(done == 1'b1, "R6 slave done", done, 1);
        exp_done = 1'b1; exp_data = 8'h7E; exp_busy = 1'b0; trk = 1'b1;
        clear_flag();

        s_xfer(8'h4D, 8'hB2, 1'b1, 1'b1, 1'b0, 16, got);
        chk(got == 8'h4D, "R9 slave trailing-sample sent", got, 8'h4D);
        chk(rd_byte == 8'hB2, "R9 slave trailing-sample received", rd_byte, 8'hB2);
        exp_done = 1'b1; exp_data = 8'hB2; trk = 1'b1;
        clear_flag();

        // R7 edges with select high
        s_xfer(8'h5A, 8'h99, 1'b1, 1'b0, 1'b1, 16, got);
        chk(rd_byte == 8'h5A, "R7 register unchanged", rd_byte, 8'h5A);
        chk(done == 1'b0, "R7 no completion", done, 0);
        exp_data = 8'h5A; trk = 1'b1;

        // R8 aborted byte then full byte
        s_xfer(8'hE7, 8'h11, 1'b0, 1'b1, 1'b0, 6, got);
        chk(done == 1'b0, "R8 no done on abort", done, 0);
        s_xfer(8'h24, 8'hC3, 1'b0, 1'b1, 1'b0, 16, got);
        chk(got == 8'h24, "R8 sent after abort", got, 8'h24);
        chk(rd_byte == 8'hC3, "R8 received after abort", rd_byte, 8'hC3);
        chk(done == 1'b1, "R8 done after abort", done, 1);
        exp_done = 1'b1; exp_data = 8'hC3; trk = 1'b1;
        clear_flag();

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule